// File: doc/BRIEF.md
# Banked Flash Data Memory Controller

This block sits between an 8-bit processor's external-data bus and a 128 KB flash data array built as two 64 KB banks. A memory control register at a special-function address holds three live fields. A bank bit becomes address bit 16 of every external-data access. A read-only ready flag reports whether the flash can take a new program operation. A pointer-select bit tells the core which of its two 16-bit data pointers is active.

External-data reads go straight through to the array in the same cycle. An external-data write while the flash is ready is passed to the array and starts a programming window of `PROG_CYCLES` clock cycles, during which the ready flag reads 0. It returns to 1 by itself when the window ends. A write that arrives during the window never reaches the array, and a sticky error output is raised. The array is programmed in 128-byte sectors. The flash cells themselves lie outside the block.

Top module: `flash_bank_ctrl`

## Requirements
- R1: After reset, a read of the control register (special-function address 0x96) returns 0x02: bank 0 (bit 0), ready (bit 1) and pointer 0 (bit 2). err_o and dps_o are 0. Reset is asynchronous and also ends any programming window that is running.
- R2: During an external-data access, fl_addr_o[16] equals the register's bank bit (bit 0) and fl_addr_o[15:0] equals xd_addr_i. A register write to bit 0 takes effect from the next cycle.
- R3: Register bit 2 is the data pointer select. Writing it sets dps_o, and the register reads it back in bit 2.
- R4: Register bits 7..3 always read 0, whatever value was written. A special-function read at any address other than 0x96 returns 0.
- R5: Register writes leave the ready flag (bit 1) unchanged, both while a programming window runs and while the flash is ready.
- R6: An external-data write while ready asserts fl_wr_o in the same cycle, with fl_wdata_o equal to xd_wdata_i. The ready flag then reads 0 for exactly PROG_CYCLES cycles and returns to 1 with no further action.
- R7: An external-data write while busy keeps fl_wr_o at 0 and leaves the array unchanged. From the next cycle err_o is 1, and it stays 1 until reset.
- R8: An external-data read asserts fl_rd_o in the same cycle and returns fl_rdata_i on xd_rdata_o in that cycle, in either bank.
- R9: Special-function writes to addresses other than 0x96 do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sfr_addr_i | input | 8 | Special-function address |
| sfr_wr_i | input | 1 | Special-function write strobe |
| sfr_wdata_i | input | 8 | Special-function write data |
| sfr_rdata_o | output | 8 | Register read data (0 when not addressed) |
| dps_o | output | 1 | Active data pointer select |
| xd_addr_i | input | 16 | External-data address from the active pointer |
| xd_rd_i | input | 1 | External-data read strobe |
| xd_wr_i | input | 1 | External-data write strobe |
| xd_wdata_i | input | 8 | External-data write data |
| xd_rdata_o | output | 8 | External-data read data |
| fl_addr_o | output | 17 | Flash array address |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_wr_o | output | 1 | Flash program strobe |
| fl_wdata_o | output | 8 | Flash program data |
| fl_rdata_i | input | 8 | Flash read data |
| err_o | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The bench measures the busy window cycle by cycle. A counter that is off by one would show a window of PROG_CYCLES plus or minus one. It writes the same address in both banks and reads each back. A bank bit that does not reach address bit 16 would return the same byte from both banks. It sends a second write into the busy window and writes the register with bit 1 set, both during the window and after it. A design that let either one through would corrupt the array, leave err_o low, or make the ready flag move under software control. Writes to other addresses and an asynchronous reset in the middle of a window check that the register keeps its value and that reset clears it back to 0x02.

// File: rtl/flash_bank_pkg.sv
package flash_bank_pkg;
  localparam int BANK_BIT = 0;
  localparam int RDY_BIT  = 1;
  localparam int DPS_BIT  = 2;

  typedef struct packed {
    logic dps;
    logic bank;
  } ctl_t;
endpackage

// File: rtl/mcon_reg.sv
module mcon_reg
  import flash_bank_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = 8'h96
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] sfr_addr_i,
  input  logic       sfr_wr_i,
  input  logic [7:0] sfr_wdata_i,
  input  logic       rdy_i,
  output ctl_t       ctl_o,
  output logic [7:0] sfr_rdata_o
);
  ctl_t ctl_q;
  logic hit;
  logic unused_wbits;

  assign hit = (sfr_addr_i == SFR_ADDR);
  assign unused_wbits = ^{sfr_wdata_i[7:3], sfr_wdata_i[RDY_BIT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (sfr_wr_i && hit) begin
      ctl_q.bank <= sfr_wdata_i[BANK_BIT];
      ctl_q.dps  <= sfr_wdata_i[DPS_BIT];
    end
  end

  always_comb begin
    sfr_rdata_o = '0;
    if (hit) begin
      sfr_rdata_o[BANK_BIT] = ctl_q.bank;
      sfr_rdata_o[RDY_BIT]  = rdy_i;
      sfr_rdata_o[DPS_BIT]  = ctl_q.dps;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic rdy_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q holds the busy cycles still to come; zero means ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i && cnt_q == '0) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdy_o = (cnt_q == '0);
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              bank_i,
  input  logic              rdy_i,
  input  logic [ADDR_W-1:0] xd_addr_i,
  input  logic              xd_rd_i,
  input  logic              xd_wr_i,
  input  logic [DATA_W-1:0] xd_wdata_i,
  output logic [DATA_W-1:0] xd_rdata_o,
  output logic [ADDR_W:0]   fl_addr_o,
  output logic              fl_rd_o,
  output logic              fl_wr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              drop_o
);
  assign fl_addr_o  = {bank_i, xd_addr_i};
  assign fl_rd_o    = xd_rd_i;
  assign xd_rdata_o = fl_rdata_i;
  assign fl_wdata_o = xd_wdata_i;
  assign fl_wr_o    = xd_wr_i & rdy_i;
  assign drop_o     = xd_wr_i & ~rdy_i;
endmodule

// File: rtl/flash_bank_ctrl.sv
module flash_bank_ctrl
  import flash_bank_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR    = 8'h96,
  parameter int         PROG_CYCLES = 40,
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  output logic              dps_o,
  input  logic [ADDR_W-1:0] xd_addr_i,
  input  logic              xd_rd_i,
  input  logic              xd_wr_i,
  input  logic [DATA_W-1:0] xd_wdata_i,
  output logic [DATA_W-1:0] xd_rdata_o,
  output logic [ADDR_W:0]   fl_addr_o,
  output logic              fl_rd_o,
  output logic              fl_wr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              err_o
);
  ctl_t ctl;
  logic rdy;
  logic bank_q;
  logic drop;
  logic err_q;

  mcon_reg #(.SFR_ADDR(SFR_ADDR)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sfr_addr_i  (sfr_addr_i),
    .sfr_wr_i    (sfr_wr_i),
    .sfr_wdata_i (sfr_wdata_i),
    .rdy_i       (rdy),
    .ctl_o       (ctl),
    .sfr_rdata_o (sfr_rdata_o)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fl_wr_o),
    .rdy_o   (rdy)
  );

  xdata_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .bank_i     (bank_q),
    .rdy_i      (rdy),
    .xd_addr_i  (xd_addr_i),
    .xd_rd_i    (xd_rd_i),
    .xd_wr_i    (xd_wr_i),
    .xd_wdata_i (xd_wdata_i),
    .xd_rdata_o (xd_rdata_o),
    .fl_addr_o  (fl_addr_o),
    .fl_rd_o    (fl_rd_o),
    .fl_wr_o    (fl_wr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_rdata_i (fl_rdata_i),
    .drop_o     (drop)
  );

  assign bank_q = ctl.bank;
  assign dps_o  = ctl.dps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   err_q <= 1'b0;
    else if (drop) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/flash_bank_ctrl_chk.sv
module flash_bank_ctrl_chk #(
  parameter int PROG_CYCLES = 40,
  parameter int ADDR_W      = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            xd_wr_i,
  input logic            fl_wr_o,
  input logic            fl_rd_o,
  input logic [ADDR_W:0] fl_addr_o,
  input logic [7:0]      sfr_rdata_o,
  input logic            err_o,
  input logic            rdy,
  input logic            bank_q
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  run_q <= 0;
    else if (rdy) run_q <= 0;
    else          run_q <= run_q + 1;
  end

  // R6
  prog_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_o |=> !rdy);
  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy |-> run_q < PROG_CYCLES);
  // R6
  busy_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy) |-> $past(run_q) == PROG_CYCLES - 1);
  // R5
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy) |-> $past(fl_wr_o));
  // R7
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xd_wr_i && !rdy) |-> !fl_wr_o);
  // R7
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xd_wr_i && !rdy) |=> err_o);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_rdata_o[7:3] == 5'd0);
  // R2
  bank_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_rd_o || fl_wr_o) |-> fl_addr_o[ADDR_W] == bank_q);
endmodule

bind flash_bank_ctrl flash_bank_ctrl_chk #(
  .PROG_CYCLES (PROG_CYCLES),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xd_wr_i     (xd_wr_i),
  .fl_wr_o     (fl_wr_o),
  .fl_rd_o     (fl_rd_o),
  .fl_addr_o   (fl_addr_o),
  .sfr_rdata_o (sfr_rdata_o),
  .err_o       (err_o),
  .rdy         (rdy),
  .bank_q      (bank_q)
);

// File: tb/tb_flash_bank_ctrl.sv
module tb_flash_bank_ctrl;
  localparam int PROG = 12;
  localparam logic [7:0] REG = 8'h96;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sfr_addr_i = REG;
  logic        sfr_wr_i = 1'b0;
  logic [7:0]  sfr_wdata_i = '0;
  logic [7:0]  sfr_rdata_o;
  logic        dps_o;
  logic [15:0] xd_addr_i = '0;
  logic        xd_rd_i = 1'b0;
  logic        xd_wr_i = 1'b0;
  logic [7:0]  xd_wdata_i = '0;
  logic [7:0]  xd_rdata_o;
  logic [16:0] fl_addr_o;
  logic        fl_rd_o, fl_wr_o;
  logic [7:0]  fl_wdata_o;
  logic [7:0]  fl_rdata_i;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  flash_bank_ctrl #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sfr_addr_i(sfr_addr_i), .sfr_wr_i(sfr_wr_i), .sfr_wdata_i(sfr_wdata_i),
    .sfr_rdata_o(sfr_rdata_o), .dps_o(dps_o),
    .xd_addr_i(xd_addr_i), .xd_rd_i(xd_rd_i), .xd_wr_i(xd_wr_i),
    .xd_wdata_i(xd_wdata_i), .xd_rdata_o(xd_rdata_o),
    .fl_addr_o(fl_addr_o), .fl_rd_o(fl_rd_o), .fl_wr_o(fl_wr_o),
    .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata_i), .err_o(err_o)
  );

  // behavioural flash cells: bank bit plus low address byte
  logic [7:0] mem [0:511];
  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  always @(posedge clk) if (fl_wr_o) mem[{fl_addr_o[16], fl_addr_o[7:0]}] <= fl_wdata_o;
  assign fl_rdata_i = mem[{fl_addr_o[16], fl_addr_o[7:0]}];

  typedef struct packed {
    logic [7:0] wr;
    logic [7:0] exp;
  } vec_t;
  // bit0 bank, bit1 ready (read-only), bit2 pointer select, 7..3 read 0
  localparam vec_t VECS [7] = '{
    '{wr: 8'h01, exp: 8'h03},
    '{wr: 8'h04, exp: 8'h06},
    '{wr: 8'h05, exp: 8'h07},
    '{wr: 8'h00, exp: 8'h02},
    '{wr: 8'hFF, exp: 8'h07},
    '{wr: 8'hFA, exp: 8'h02},
    '{wr: 8'hFD, exp: 8'h07}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr_i = a; sfr_wr_i = 1'b1; sfr_wdata_i = d;
    @(negedge clk);
    sfr_wr_i = 1'b0; sfr_addr_i = REG;
  endtask

  task automatic xwrite(input logic [15:0] a, input logic [7:0] d, input logic exp_wr);
    @(negedge clk);
    xd_addr_i = a; xd_wdata_i = d; xd_wr_i = 1'b1;
    #1;
    chk("R6/R7 fl_wr_o", fl_wr_o, exp_wr);
    if (exp_wr) chk("R6 fl_wdata_o", fl_wdata_o, d);
    @(negedge clk);
    xd_wr_i = 1'b0;
  endtask

  // count sampled cycles with the ready flag low
  task automatic busy_count(output int n);
    n = 0;
    while (sfr_rdata_o[1] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic xread(input logic [15:0] a, input logic [16:0] exp_addr, input logic [7:0] exp_d);
    @(negedge clk);
    xd_addr_i = a; xd_rd_i = 1'b1;
    #1;
    chk("R8 fl_rd_o", fl_rd_o, 1'b1);
    chk("R2 fl_addr_o", fl_addr_o, exp_addr);
    chk("R8 xd_rdata_o", xd_rdata_o, exp_d);
    @(negedge clk);
    xd_rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset reg", sfr_rdata_o, 8'h02);
    chk("R1 reset err", err_o, 1'b0);
    chk("R1 reset dps", dps_o, 1'b0);
    rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 register fields
    foreach (VECS[i]) begin
      reg_write(REG, VECS[i].wr);
      #1;
      chk("R2 R3 R4 R5 reg readback", sfr_rdata_o, VECS[i].exp);
      chk("R3 dps_o", dps_o, VECS[i].exp[2]);
    end

    // R9 other address write ignored; R4 other address reads 0
    reg_write(8'h97, 8'h00);
    #1;
    chk("R9 reg after foreign write", sfr_rdata_o, 8'h07);
    sfr_addr_i = 8'h97;
    #1;
    chk("R4 foreign read", sfr_rdata_o, 8'h00);
    sfr_addr_i = REG;

    // R6 write in bank 0, exact busy length
    reg_write(REG, 8'h00);
    xwrite(16'h0012, 8'hA5, 1'b1);
    busy_count(n);
    chk("R6 busy cycles", n, PROG);
    chk("R6 ready again", sfr_rdata_o[1], 1'b1);

    // bank 1 write, then a write inside the window (R7)
    reg_write(REG, 8'h01);
    xwrite(16'h0012, 8'h5A, 1'b1);
    chk("R7 err before drop", err_o, 1'b0);
    xwrite(16'h0013, 8'hEE, 1'b0);
    chk("R7 err set", err_o, 1'b1);
    busy_count(n);
    chk("R7 err sticky", err_o, 1'b1);

    // R8 R2 reads in both banks
    xread(16'h0012, 17'h10012, 8'h5A);
    xread(16'h0013, 17'h10013, 8'h00);
    reg_write(REG, 8'h00);
    xread(16'h0012, 17'h00012, 8'hA5);

    // R5 register writes with bit 1 set during and after a window
    xwrite(16'h0020, 8'h33, 1'b1);
    reg_write(REG, 8'h02);
    #1;
    chk("R5 busy kept", sfr_rdata_o[1], 1'b0);
    busy_count(n);
    chk("R5 window length", n, PROG - 2);
    reg_write(REG, 8'h00);
    #1;
    chk("R5 ready kept", sfr_rdata_o[1], 1'b1);
    chk("R7 err still set", err_o, 1'b1);

    // R1 asynchronous reset in the middle of a window
    reg_write(REG, 8'h05);
    xwrite(16'h0030, 8'h44, 1'b1);
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-window reset reg", sfr_rdata_o, 8'h02);
    chk("R1 mid-window reset err", err_o, 1'b0);
    chk("R1 mid-window reset dps", dps_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule